// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block is the interrupt logic for one bank of general-purpose input pins. Each pin is set up on its own to detect either a level or an edge. A polarity bit chooses active-high level or rising edge, or active-low level or falling edge. For edge pins, a both-edges bit makes the pin trigger on either edge. Inputs pass through a two-flop synchroniser. A detected event sets a sticky pending bit for that pin. Software clears pending bits by writing ones to them.

Software sets the mask through two write-one registers. One register only unmasks pins and the other only masks them, so no read-modify-write is needed. The resulting mask can be read back. Pending bits are recorded whether or not the pin is masked. The single bank interrupt output is high while any pin is both pending and unmasked. Access is through a simple register bus: address, write enable, write data, and combinational read data.

Top module: `gpio_pin_irq_bank`

## Requirements
- R1: While reset is low, the pending register (address 3) reads 0. After reset the mask reads all ones, and the type, polarity and both-edges registers read 0, with `irq_o` low.
- R2: Writing address 1 unmasks every pin whose write-data bit is 1. Pins whose bit is 0 keep their mask state.
- R3: Writing address 2 masks every pin whose write-data bit is 1. Pins whose bit is 0 keep their mask state.
- R4: Address 0 reads the mask, with bit i equal to 1 when pin i is masked. Addresses 1, 2 and 7 read 0.
- R5: Writing address 3 clears each pending bit written as 1 and leaves bits written as 0 unchanged.
- R6: The type register (address 4), polarity register (address 5) and both-edges register (address 6) each hold one bit per pin, with bit i for pin i. A write replaces the whole word, and a read returns it.
- R7: A pin with type bit 0 is level sensitive and pends while its synchronised input equals its polarity bit. A change on `pin_i` is first seen in the pending register after the third rising clock edge that follows it.
- R8: A pending bit stays set until it is cleared. A clear has no effect on a level pin while its active level is still present.
- R9: A pin with type bit 1 and both-edges bit 0 pends on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0.
- R10: A pin with type bit 1 and both-edges bit 1 pends on either edge, whatever its polarity bit.
- R11: Pending bits are recorded even for masked pins. `irq_o` is high exactly when some pin is both pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | PIN_W | Asynchronous pin inputs, bit i is pin i |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Bank interrupt request |

## Verification
The hardest case to reach is a pin whose pending bit must stay set across a clear because its level is still active, and that then must stay set after the level goes away. Reaching it also requires that the pin's edge-type neighbours, under the same stimulus, do not pend. The bench rotates six pin modes across all pins, so every pin takes every mode. For each rotation it drives all four start/end pin value pairs. It issues a clear while the start level is held, and again after the change. This drives sticky level bits, spurious edges, and polarity that must be ignored on both-edge pins into the same pending word. The expected word is computed per pin from the mode and the two values.

// File: rtl/gpio_irq_pkg.sv
// Shared register addresses for the GPIO bank interrupt controller.
// Assumes a 3-bit word address; the numbering is part of the bus contract.
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK    = 3'd0,
        RA_UNMASK  = 3'd1,
        RA_SETMASK = 3'd2,
        RA_PEND    = 3'd3,
        RA_KIND    = 3'd4,
        RA_POL     = 3'd5,
        RA_BOTH    = 3'd6,
        RA_SPARE   = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
// Two-flop synchroniser for a vector of asynchronous pin inputs.
// Assumes each bit is independent; there is no bus-coherence guarantee across bits.
module gpio_irq_sync #(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] async_i,
    output logic [PIN_W-1:0] sync_o
);
    logic [PIN_W-1:0] meta_q;
    logic [PIN_W-1:0] sync_q;

    // Purpose: two register stages to resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/gpio_irq_cfg.sv
// Configuration and mask registers for one pin bank.
// The mask is changed only through set-only and clear-only writes.
// The type, polarity and both-edges words are replaced whole on a write.
// Assumes at most one write per cycle.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PIN_W-1:0]  wdata_i,
    output logic [PIN_W-1:0]  mask_o,
    output logic [PIN_W-1:0]  kind_o,
    output logic [PIN_W-1:0]  pol_o,
    output logic [PIN_W-1:0]  both_o
);
    logic [PIN_W-1:0] mask_q, kind_q, pol_q, both_q;

    // Purpose: apply register writes; reset masks every pin and zeroes the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            kind_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (we_i) begin
            case (reg_addr_e'(addr_i))
                RA_UNMASK:  mask_q <= mask_q & ~wdata_i;
                RA_SETMASK: mask_q <= mask_q | wdata_i;
                RA_KIND:    kind_q <= wdata_i;
                RA_POL:     pol_q  <= wdata_i;
                RA_BOTH:    both_q <= wdata_i;
                default:    ;
            endcase
        end
    end

    assign mask_o = mask_q;
    assign kind_o = kind_q;
    assign pol_o  = pol_q;
    assign both_o = both_q;

    // R2
    unmask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == RA_UNMASK) |=> ((mask_q & $past(wdata_i)) == '0));

    // R3
    setmask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == RA_SETMASK) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

    // R2, R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && (addr_i == RA_UNMASK || addr_i == RA_SETMASK)) |=> $stable(mask_q));
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin event detector. The input is the synchronised pin vector; the
// module keeps its value from one clock earlier to find edges. A level pin
// reports an event in every cycle its active level is present.
module gpio_irq_detect #(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] cur_i,
    input  logic [PIN_W-1:0] kind_i,
    input  logic [PIN_W-1:0] pol_i,
    input  logic [PIN_W-1:0] both_i,
    output logic [PIN_W-1:0] evt_o
);
    logic [PIN_W-1:0] prev_q;

    // Purpose: remember last cycle's synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_i;
    end

    for (genvar g = 0; g < PIN_W; g++) begin : g_pin
        logic rise, fall;
        assign rise = cur_i[g] & ~prev_q[g];
        assign fall = ~cur_i[g] & prev_q[g];
        assign evt_o[g] = kind_i[g]
                        ? (both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall))
                        : ~(cur_i[g] ^ pol_i[g]);
    end

    // R9, R10
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & kind_i & ~(cur_i ^ prev_q)) == '0));
endmodule

// File: rtl/gpio_pin_irq_bank.sv
// Top level of the GPIO bank interrupt controller. It ties the synchroniser,
// detector and configuration registers together. It holds the sticky pending
// word, decodes reads and forms the bank interrupt. In any one cycle a new
// event takes priority over a clear of the same bit.
module gpio_pin_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    output logic              irq_o
);
    logic [PIN_W-1:0] pin_s, evt, mask, kind, pol, both;
    logic [PIN_W-1:0] pend_q, clr_bits;

    gpio_irq_sync #(.PIN_W(PIN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_s)
    );

    gpio_irq_detect #(.PIN_W(PIN_W)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (pin_s),
        .kind_i (kind),
        .pol_i  (pol),
        .both_i (both),
        .evt_o  (evt)
    );

    gpio_irq_cfg #(.PIN_W(PIN_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .mask_o  (mask),
        .kind_o  (kind),
        .pol_o   (pol),
        .both_o  (both)
    );

    assign clr_bits = (bus_we && bus_addr == RA_PEND) ? bus_wdata : '0;

    // Purpose: sticky pending bits, cleared by write-one, with set winning over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_bits) | evt;
    end

    // Purpose: read-data decode; write-only and spare addresses read zero.
    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_MASK: bus_rdata = mask;
            RA_PEND: bus_rdata = pend_q;
            RA_KIND: bus_rdata = kind;
            RA_POL:  bus_rdata = pol;
            RA_BOTH: bus_rdata = both;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = |(pend_q & ~mask);

    // R5
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RA_PEND)
        |=> ((pend_q & $past(bus_wdata) & ~$past(evt)) == '0));

    // R7
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));

    // R8
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(clr_bits)) & ~pend_q) == '0));

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq_o);
endmodule

// File: tb/sim_gpio_pin_irq_bank.sv
module sim_gpio_pin_irq_bank;
    localparam int W = 32;
    localparam logic [2:0] A_MASK = 3'd0, A_UNM = 3'd1, A_SETM = 3'd2, A_PEND = 3'd3;
    localparam logic [2:0] A_KIND = 3'd4, A_POL = 3'd5, A_BOTH = 3'd6, A_SPARE = 3'd7;

    logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, irq_o;
    logic [W-1:0] pin_i = '0, bus_wdata = '0, bus_rdata;
    logic [2:0] bus_addr = '0;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    gpio_pin_irq_bank #(.PIN_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Mode m: 0 level-low, 1 level-high, 2 falling, 3 rising, 4 both (pol 0), 5 both (pol 1)
    function automatic logic hit(input int m, input logic v0, input logic v1);
        logic lvl_pol;
        lvl_pol = (m == 1);
        if (m < 2) return (v0 == lvl_pol) || (v1 == lvl_pol);
        if (v0 == v1) return 1'b0;
        if (m >= 4) return 1'b1;
        return (m == 3) ? v1 : ~v1;
    endfunction

    initial begin
        logic [W-1:0] d, kind_v, pol_v, both_v, exp_v, lvl_v, en;
        int mode [W];

        // R1: pending reads zero while reset is low
        repeat (3) @(negedge clk);
        rd(A_PEND, d); chk("R1 pend in reset", d, '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_MASK, d); chk("R1 mask after reset", d, '1);
        rd(A_KIND, d); chk("R1 type after reset", d, '0);
        rd(A_POL, d);  chk("R1 pol after reset", d, '0);
        rd(A_BOTH, d); chk("R1 both after reset", d, '0);
        chk("R1 irq after reset", {31'b0, irq_o}, '0);

        // R6: full-word config writes read back
        wr(A_KIND, 32'hA5A5_1234); rd(A_KIND, d); chk("R6 type", d, 32'hA5A5_1234);
        wr(A_POL,  32'h0F0F_F0F0); rd(A_POL, d);  chk("R6 pol", d, 32'h0F0F_F0F0);
        wr(A_BOTH, 32'h8000_0001); rd(A_BOTH, d); chk("R6 both", d, 32'h8000_0001);
        wr(A_KIND, 32'h0000_00FF); rd(A_KIND, d); chk("R6 type replace", d, 32'h0000_00FF);

        // R2, R3, R4: set-only and clear-only mask writes
        wr(A_UNM, 32'h0000_00F0);  rd(A_MASK, d); chk("R2 unmask", d, 32'hFFFF_FF0F);
        wr(A_UNM, 32'h0000_0000);  rd(A_MASK, d); chk("R2 zero write keeps", d, 32'hFFFF_FF0F);
        wr(A_SETM, 32'h0000_0030); rd(A_MASK, d); chk("R3 mask", d, 32'hFFFF_FF3F);
        wr(A_UNM, 32'hF000_0001);  rd(A_MASK, d); chk("R2 unmask more", d, 32'h0FFF_FF3E);
        wr(A_SETM, 32'hFFFF_FFFF); rd(A_MASK, d); chk("R3 mask all", d, '1);
        rd(A_UNM, d);   chk("R4 unmask reads zero", d, '0);
        rd(A_SETM, d);  chk("R4 setmask reads zero", d, '0);
        rd(A_SPARE, d); chk("R4 spare reads zero", d, '0);

        // R7: level-high latency, pending appears after the third edge
        wr(A_KIND, '0); wr(A_POL, '1); wr(A_BOTH, '0);
        pin_i = '0;
        repeat (4) @(negedge clk);
        wr(A_PEND, '1);
        rd(A_PEND, d); chk("R7 idle level-high", d, '0);
        pin_i = 32'h1;
        repeat (2) @(negedge clk);
        rd(A_PEND, d); chk("R7 not yet after two edges", d, '0);
        @(negedge clk);
        rd(A_PEND, d); chk("R7 set after third edge", d, 32'h1);
        pin_i = '0;

        // R5: partial write-one clear on edge-captured bits
        wr(A_KIND, '1); wr(A_POL, '1);
        repeat (4) @(negedge clk);
        wr(A_PEND, '1);
        pin_i = '1;
        repeat (4) @(negedge clk);
        rd(A_PEND, d); chk("R9 rising all", d, '1);
        wr(A_PEND, 32'h0000_FFFF);
        rd(A_PEND, d); chk("R5 partial clear", d, 32'hFFFF_0000);
        wr(A_PEND, 32'h0000_0000);
        rd(A_PEND, d); chk("R5 zero write keeps", d, 32'hFFFF_0000);

        // Sweep: every pin through every mode and every value pair (R7..R11)
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < W; i++) begin
                mode[i] = (i + r) % 6;
                kind_v[i] = (mode[i] >= 2);
                pol_v[i]  = (mode[i] == 1) || (mode[i] == 3) || (mode[i] == 5);
                both_v[i] = (mode[i] >= 4);
                lvl_v[i]  = (mode[i] < 2);
            end
            wr(A_KIND, kind_v); wr(A_POL, pol_v); wr(A_BOTH, both_v);
            for (int t = 0; t < 4; t++) begin
                logic v0, v1;
                v0 = t[1]; v1 = t[0];
                wr(A_SETM, '1);
                pin_i = {W{v0}};
                repeat (6) @(negedge clk);
                wr(A_PEND, '1);
                for (int i = 0; i < W; i++)
                    exp_v[i] = lvl_v[i] && (v0 == pol_v[i]);
                rd(A_PEND, d); chk("R8 clear under active level", d, exp_v);
                pin_i = {W{v1}};
                repeat (4) @(negedge clk);
                for (int i = 0; i < W; i++) exp_v[i] = hit(mode[i], v0, v1);
                rd(A_PEND, d); chk("R9 R10 R7 pend after change", d, exp_v);
                chk("R11 masked irq low", {31'b0, irq_o}, '0);
                en = 32'h1 << ((r * 5 + t * 3) % W);
                wr(A_UNM, en);
                chk("R11 irq unmasked", {31'b0, irq_o}, {31'b0, |(exp_v & en)});
                wr(A_PEND, '1);
                for (int i = 0; i < W; i++)
                    exp_v[i] = lvl_v[i] && (v1 == pol_v[i]);
                rd(A_PEND, d); chk("R8 clear after level change", d, exp_v);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule